// File: doc/BRIEF.md
# Exception Entry Controller

This block decides, each clock, whether a 32-bit RISC core enters an exception, and performs the whole entry in one step. It looks at three request sources: a synchronous exception request that carries a cause number, a level-sensitive external interrupt, and a level-sensitive tick-timer interrupt. Each interrupt is gated by its own enable bit in the status register, and the three sources are ranked by a fixed priority.

When an entry is accepted, the block does four things on the same clock edge. It stores the return address, adjusted for delay-slot and system-call cases, in the exception PC register. It copies the status register into the saved-status register. It rewrites the status register into a supervisor state with translation and interrupts off. It then drives the vector PC together with a one-cycle TLB flush pulse. The core can also write the status register directly when no entry is taking place. A synchronous request with an unusable cause number is refused and leaves a sticky error flag set.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Reset holds the status register at 0x00000001 (supervisor bit set), the exception PC and saved status at 0, and take, flush, delay-slot-clear and error outputs at 0.
- R2: An external interrupt is accepted only while status bit 2 (interrupt enable) is 1. Otherwise it produces no entry and changes no register.
- R3: A tick interrupt is accepted only while status bit 1 (tick enable) is 1. Otherwise it produces no entry and changes no register.
- R4: When enabled tick and external interrupts are both pending, the tick entry (cause 5) is taken rather than the external one (cause 8).
- R5: A synchronous request is served ahead of any pending interrupt in the same cycle.
- R6: Without delay-slot or system-call adjustment, the exception PC receives the current PC.
- R7: When the delay-slot input is 1 at entry, the exception PC is the PC minus 4, status bit 13 (delay-slot marker) is set, and the delay-slot-clear output pulses.
- R8: A synchronous entry with cause 12 (system call) adds 4 to the exception PC. This adjustment combines with the delay-slot one.
- R9: The saved-status register receives the status value as it was just before the entry.
- R10: On entry the status register sets bit 0 (supervisor), clears bits 1, 2, 5 and 6 (tick enable, interrupt enable, data and instruction translation enable), and keeps all other bits.
- R11: The vector PC equals the cause shifted left by 8. Only causes 1 to 13 are valid.
- R12: Every entry raises take and TLB flush for exactly the one cycle after the accepting edge, and all registers show their new values in that same cycle.
- R13: A synchronous request with cause 0 or a cause of 14 or more causes no entry, no flush and no register change, and it sets an error output that stays 1 until reset.
- R14: A status write with no entry in the same cycle loads the written value into the status register. An entry takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | PC of the instruction at which the exception is taken |
| in_dslot_i | input | 1 | That instruction sits in a branch delay slot |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | 5 | Cause number of the synchronous request |
| irq_ext_i | input | 1 | External interrupt pending (level) |
| irq_tick_i | input | 1 | Tick-timer interrupt pending (level) |
| sr_we_i | input | 1 | Status register write strobe |
| sr_wdata_i | input | 32 | Status register write data |
| take_o | output | 1 | Entry performed (one-cycle pulse) |
| new_pc_o | output | 32 | Vector PC, valid while take_o is 1 |
| tlb_flush_o | output | 1 | TLB flush request pulse |
| dslot_clr_o | output | 1 | Pulse that clears the core's delay-slot flag |
| epcr_o | output | 32 | Exception PC register |
| esr_o | output | 32 | Saved status register |
| sr_o | output | 32 | Current status register |
| cause_err_o | output | 1 | Sticky flag for a refused synchronous cause |

## Verification
The bench builds the block with its defaults: 32-bit PC, 14 cause slots, vector shift 8, tick cause 5, external cause 8 and system-call cause 12. With these values, causes 13 and 14 fall on either side of the validity edge, and the two interrupt vectors come out as 0x500 and 0x800. The system-call and delay-slot adjustments can be seen alone and then together, where they cancel. Back-to-back synchronous requests and level interrupts that stay pending after their enable bits are cleared cover the cases where an entry repeats or must not repeat.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int CAUSE_W     = 5;
    localparam int INSN_BYTES  = 4;

    // Status register bit positions
    localparam int SR_SM  = 0;
    localparam int SR_TEE = 1;
    localparam int SR_IEE = 2;
    localparam int SR_DME = 5;
    localparam int SR_IME = 6;
    localparam int SR_DSX = 13;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SYNC = 2'd1,
        SRC_TICK = 2'd2,
        SRC_EXT  = 2'd3
    } src_e;

    typedef struct packed {
        logic               take;
        logic               bad;
        src_e               src;
        logic [CAUSE_W-1:0] cause;
    } grant_t;

    function automatic logic cause_ok(input logic [CAUSE_W-1:0] c, input int limit);
        logic [CAUSE_W:0] lim;
        lim = (CAUSE_W+1)'(limit);
        return (c != '0) && ({1'b0, c} < lim);
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int NUM_CAUSES = 14,
    parameter int TICK_CAUSE = 5,
    parameter int EXT_CAUSE  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               irq_ext,
    input  logic               irq_tick,
    input  logic               iee,
    input  logic               tee,
    output grant_t             grant
);
    localparam logic [CAUSE_W-1:0] TICK_C = CAUSE_W'(TICK_CAUSE);
    localparam logic [CAUSE_W-1:0] EXT_C  = CAUSE_W'(EXT_CAUSE);

    logic tick_ok, ext_ok;

    assign tick_ok = irq_tick && tee;
    assign ext_ok  = irq_ext && iee;

    always_comb begin
        grant = '{take: 1'b0, bad: 1'b0, src: SRC_NONE, cause: '0};
        if (exc_req) begin
            if (cause_ok(exc_cause, NUM_CAUSES)) begin
                grant.take  = 1'b1;
                grant.src   = SRC_SYNC;
                grant.cause = exc_cause;
            end else begin
                grant.bad = 1'b1;
            end
        end else if (tick_ok) begin
            grant.take  = 1'b1;
            grant.src   = SRC_TICK;
            grant.cause = TICK_C;
        end else if (ext_ok) begin
            grant.take  = 1'b1;
            grant.src   = SRC_EXT;
            grant.cause = EXT_C;
        end
    end

    // R2: external source only granted while enabled
    a_r2_ext_gated: assert property (@(posedge clk) disable iff (rst)
        (grant.src == SRC_EXT) |-> (iee && irq_ext));

    // R3: tick source only granted while enabled
    a_r3_tick_gated: assert property (@(posedge clk) disable iff (rst)
        (grant.src == SRC_TICK) |-> (tee && irq_tick));

    // R4: tick beats external
    a_r4_tick_over_ext: assert property (@(posedge clk) disable iff (rst)
        (!exc_req && irq_tick && tee && irq_ext && iee) |-> (grant.src == SRC_TICK));

    // R5: synchronous request served first
    a_r5_sync_first: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (grant.src == SRC_SYNC || grant.bad));

endmodule

// File: rtl/exc_retaddr.sv
module exc_retaddr
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic            in_dslot,
    input  logic            is_syscall,
    output logic [XLEN-1:0] epcr_next
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] back, fwd;

    assign back      = in_dslot   ? STEP : '0;
    assign fwd       = is_syscall ? STEP : '0;
    assign epcr_next = pc - back + fwd;

endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int VEC_SHIFT = 8
) (
    input  logic [XLEN-1:0]    sr,
    input  logic               in_dslot,
    input  logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    sr_next,
    output logic [XLEN-1:0]    vector
);
    always_comb begin
        sr_next         = sr;
        sr_next[SR_SM]  = 1'b1;
        sr_next[SR_TEE] = 1'b0;
        sr_next[SR_IEE] = 1'b0;
        sr_next[SR_DME] = 1'b0;
        sr_next[SR_IME] = 1'b0;
        if (in_dslot) sr_next[SR_DSX] = 1'b1;
    end

    assign vector = XLEN'(cause) << VEC_SHIFT;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int              XLEN          = 32,
    parameter int              NUM_CAUSES    = 14,
    parameter int              VEC_SHIFT     = 8,
    parameter int              TICK_CAUSE    = 5,
    parameter int              EXT_CAUSE     = 8,
    parameter int              SYSCALL_CAUSE = 12,
    parameter logic [XLEN-1:0] SR_RESET      = XLEN'(1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [XLEN-1:0]    pc_i,
    input  logic               in_dslot_i,
    input  logic               exc_req_i,
    input  logic [CAUSE_W-1:0] exc_cause_i,
    input  logic               irq_ext_i,
    input  logic               irq_tick_i,
    input  logic               sr_we_i,
    input  logic [XLEN-1:0]    sr_wdata_i,
    output logic               take_o,
    output logic [XLEN-1:0]    new_pc_o,
    output logic               tlb_flush_o,
    output logic               dslot_clr_o,
    output logic [XLEN-1:0]    epcr_o,
    output logic [XLEN-1:0]    esr_o,
    output logic [XLEN-1:0]    sr_o,
    output logic               cause_err_o
);
    localparam logic [CAUSE_W-1:0] SYSCALL_C = CAUSE_W'(SYSCALL_CAUSE);

    logic [XLEN-1:0] sr_q, epcr_q, esr_q, vec_q;
    logic            take_q, flush_q, dclr_q, err_q;

    grant_t          grant;
    logic            is_syscall;
    logic [XLEN-1:0] epcr_nx, sr_nx, vec_nx;

    exc_arbiter #(
        .NUM_CAUSES (NUM_CAUSES),
        .TICK_CAUSE (TICK_CAUSE),
        .EXT_CAUSE  (EXT_CAUSE)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .exc_req   (exc_req_i),
        .exc_cause (exc_cause_i),
        .irq_ext   (irq_ext_i),
        .irq_tick  (irq_tick_i),
        .iee       (sr_q[SR_IEE]),
        .tee       (sr_q[SR_TEE]),
        .grant     (grant)
    );

    assign is_syscall = (grant.src == SRC_SYNC) && (grant.cause == SYSCALL_C);

    exc_retaddr #(.XLEN(XLEN)) u_ret (
        .pc         (pc_i),
        .in_dslot   (in_dslot_i),
        .is_syscall (is_syscall),
        .epcr_next  (epcr_nx)
    );

    exc_sr_update #(.XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT)) u_sr (
        .sr       (sr_q),
        .in_dslot (in_dslot_i),
        .cause    (grant.cause),
        .sr_next  (sr_nx),
        .vector   (vec_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q    <= SR_RESET;
            epcr_q  <= '0;
            esr_q   <= '0;
            vec_q   <= '0;
            take_q  <= 1'b0;
            flush_q <= 1'b0;
            dclr_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            take_q  <= grant.take;
            flush_q <= grant.take;
            dclr_q  <= grant.take && in_dslot_i;
            err_q   <= err_q | grant.bad;
            if (grant.take) begin
                epcr_q <= epcr_nx;
                esr_q  <= sr_q;
                sr_q   <= sr_nx;
                vec_q  <= vec_nx;
            end else if (sr_we_i) begin
                sr_q <= sr_wdata_i;
            end
        end
    end

    assign take_o      = take_q;
    assign new_pc_o    = vec_q;
    assign tlb_flush_o = flush_q;
    assign dslot_clr_o = dclr_q;
    assign epcr_o      = epcr_q;
    assign esr_o       = esr_q;
    assign sr_o        = sr_q;
    assign cause_err_o = err_q;

    // R9: saved status equals status before the entry
    a_r9_esr_copy: assert property (@(posedge clk) disable iff (rst)
        grant.take |=> (esr_q == $past(sr_q)));

    // R10: status after entry is supervisor with enables off
    a_r10_sr_entry: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (sr_q[SR_SM] && !sr_q[SR_IEE] && !sr_q[SR_TEE]
                    && !sr_q[SR_DME] && !sr_q[SR_IME]));

    // R11: vector is aligned to the vector spacing
    a_r11_vec_aligned: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (vec_q[VEC_SHIFT-1:0] == '0 && vec_q != '0));

    // R12: flush never appears without an entry
    a_r12_flush_take: assert property (@(posedge clk) disable iff (rst)
        flush_q |-> take_q);

    // R13: error flag is sticky, refused request does not enter
    a_r13_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    a_r13_bad_no_take: assert property (@(posedge clk) disable iff (rst)
        grant.bad |=> (!take_q && $stable(sr_q) && $stable(epcr_q)));

endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0;
    logic        in_dslot_i = 1'b0;
    logic        exc_req_i = 1'b0;
    logic [4:0]  exc_cause_i = '0;
    logic        irq_ext_i = 1'b0;
    logic        irq_tick_i = 1'b0;
    logic        sr_we_i = 1'b0;
    logic [31:0] sr_wdata_i = '0;
    logic        take_o, tlb_flush_o, dslot_clr_o, cause_err_o;
    logic [31:0] new_pc_o, epcr_o, esr_o, sr_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl dut_i (
        .clk(clk), .rst(rst), .pc_i(pc_i), .in_dslot_i(in_dslot_i),
        .exc_req_i(exc_req_i), .exc_cause_i(exc_cause_i),
        .irq_ext_i(irq_ext_i), .irq_tick_i(irq_tick_i),
        .sr_we_i(sr_we_i), .sr_wdata_i(sr_wdata_i),
        .take_o(take_o), .new_pc_o(new_pc_o), .tlb_flush_o(tlb_flush_o),
        .dslot_clr_o(dslot_clr_o), .epcr_o(epcr_o), .esr_o(esr_o),
        .sr_o(sr_o), .cause_err_o(cause_err_o)
    );

    typedef struct {
        string       tag;
        logic        take;
        logic        dclr;
        logic [31:0] vec;
        logic [31:0] epcr;
        logic [31:0] esr;
        logic [31:0] sr;
        logic        err;
    } exp_t;

    exp_t exp_q[$];

    // reference state
    logic [31:0] m_sr = 32'h1, m_epcr = '0, m_esr = '0;
    logic        m_err = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic req, input logic [4:0] cause,
                         input logic ext, input logic tick, input logic ds,
                         input logic [31:0] pc, input logic we, input logic [31:0] wd);
        exp_t e;
        logic take, bad;
        logic [4:0] c;
        @(negedge clk);
        exc_req_i = req; exc_cause_i = cause; irq_ext_i = ext; irq_tick_i = tick;
        in_dslot_i = ds; pc_i = pc; sr_we_i = we; sr_wdata_i = wd;
        take = 1'b0; bad = 1'b0; c = '0;
        if (req) begin
            if (cause != 0 && cause < 14) begin take = 1'b1; c = cause; end
            else bad = 1'b1;
        end else if (tick && m_sr[1]) begin take = 1'b1; c = 5'd5; end
        else if (ext && m_sr[2]) begin take = 1'b1; c = 5'd8; end
        e.tag = tag; e.take = take; e.dclr = take && ds; e.vec = 32'(c) << 8;
        if (take) begin
            m_epcr = pc - (ds ? 32'd4 : 32'd0) + ((req && cause == 5'd12) ? 32'd4 : 32'd0);
            m_esr  = m_sr;
            m_sr   = (m_sr | 32'h1 | (ds ? 32'h2000 : 32'h0)) & ~32'h66;
        end else if (we) begin
            m_sr = wd;
        end
        m_err = m_err | bad;
        e.epcr = m_epcr; e.esr = m_esr; e.sr = m_sr; e.err = m_err;
        exp_q.push_back(e);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, " take R12"}, 32'(take_o), 32'(e.take));
            chk({e.tag, " flush R12"}, 32'(tlb_flush_o), 32'(e.take));
            chk({e.tag, " dslot_clr R7"}, 32'(dslot_clr_o), 32'(e.dclr));
            if (e.take) chk({e.tag, " vector R11"}, new_pc_o, e.vec);
            chk({e.tag, " epcr R6"}, epcr_o, e.epcr);
            chk({e.tag, " esr R9"}, esr_o, e.esr);
            chk({e.tag, " sr R10"}, sr_o, e.sr);
            chk({e.tag, " err R13"}, 32'(cause_err_o), 32'(e.err));
        end
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset values
        chk("R1 sr", sr_o, 32'h1);
        chk("R1 epcr", epcr_o, 32'h0);
        chk("R1 esr", esr_o, 32'h0);
        chk("R1 pulses", {29'd0, take_o, tlb_flush_o, dslot_clr_o}, 32'h0);
        chk("R1 err", 32'(cause_err_o), 32'h0);
        @(negedge clk); rst = 1'b0;

        drive("R14 write", 0, 0, 0, 0, 0, 32'h0, 1, 32'h1);
        drive("R2 ext masked", 0, 0, 1, 0, 0, 32'h100, 0, 0);
        drive("R3 tick masked", 0, 0, 0, 1, 0, 32'h104, 0, 0);
        drive("R14 enable all", 0, 0, 0, 0, 0, 32'h0, 1, 32'h67);
        drive("R4 tick wins", 0, 0, 1, 1, 0, 32'h1000, 0, 0);
        drive("R2 R3 no retrigger", 0, 0, 1, 1, 0, 32'h1004, 0, 0);
        drive("R14 reenable", 0, 0, 0, 0, 0, 32'h0, 1, 32'h67);
        drive("R7 ext dslot", 0, 0, 1, 0, 1, 32'h2004, 0, 0);
        drive("R14 write 7", 0, 0, 0, 0, 0, 32'h0, 1, 32'h7);
        drive("R5 R8 syscall", 1, 5'd12, 1, 1, 0, 32'h3000, 0, 0);
        drive("R8 syscall dslot", 1, 5'd12, 0, 0, 1, 32'h4004, 0, 0);
        drive("R6 cause 2", 1, 5'd2, 0, 0, 0, 32'h5000, 0, 0);
        drive("R11 cause 13", 1, 5'd13, 0, 0, 0, 32'h6000, 0, 0);
        drive("R14 entry beats write", 1, 5'd1, 0, 0, 0, 32'h7000, 1, 32'hFFFF);
        drive("R13 cause 0", 1, 5'd0, 0, 0, 0, 32'h8000, 0, 0);
        drive("R13 cause 14", 1, 5'd14, 0, 0, 0, 32'h8004, 0, 0);
        drive("R13 idle sticky", 0, 0, 0, 0, 0, 32'h0, 0, 0);
        drive("R14 enable ext", 0, 0, 0, 0, 0, 32'h0, 1, 32'h4);
        drive("R5 bad sync blocks ext", 1, 5'd31, 1, 0, 0, 32'h9000, 0, 0);
        drive("R2 ext taken", 0, 0, 1, 0, 0, 32'h9000, 0, 0);
        drive("R12 idle", 0, 0, 0, 0, 0, 32'h0, 0, 0);
        drive("R12 idle2", 0, 0, 0, 0, 0, 32'h0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule